// File: doc/BRIEF.md
# Delayed Read Target Controller

This block is the target-side control for a parallel bus target that answers reads from a local read FIFO. When delayed mode is enabled (`dly_en_n` low), the first read that hits one of the target's address windows is not served. Its address, command and byte enables are captured as a pending request, and the attempt ends in a retry. The application sees `req_pend` along with the captured fields, fetches the data and fills the read FIFO. Reads that do not match, and matching reads that arrive before the FIFO has data, are retried. When the same read is repeated and the FIFO has data, the target serves it word by word. It disconnects if the FIFO runs dry, and then drops the pending request.

When delayed mode is disabled and nothing is pending, a hit is served at once from the FIFO. The FIFO read side is a valid/ready stream. `rd_valid` must not depend on `rd_ready`. `rd_ready` depends on `rd_valid` and on the initiator's IRDY, so the initiator's wait states are the only back-pressure on the FIFO. One word leaves the FIFO in each cycle in which both `rd_valid` and `rd_ready` are high.

Top module: `dlyrd_target`

## Requirements
- R1: After reset, and while `rst_n` is low, `devsel_n`, `trdy_n` and `stop_n` are high, and `req_pend` and `rd_ready` are low.
- R2: An address phase is the first cycle of `frame_n` low after it was high. The target claims the transaction, driving `devsel_n` low from the next cycle, only if `bar_hit` is high and `cmd` is a read code: 4'b0010 I/O read, 4'b0110 memory read, 4'b1100 memory read multiple or 4'b1110 memory read line. In every other case all outputs stay idle.
- R3: With `dly_en_n` high and no request pending, a claimed read enters data phases. In each data phase `trdy_n` is low exactly when `rd_valid` is high, and a word moves, with `rd_ready` high, when `trdy_n` and `irdy_n` are both low.
- R4: With `dly_en_n` low and no request pending, a claimed read captures `addr`, `cmd` and `be_n` into `req_addr`, `req_cmd` and `req_be_n`. It sets `req_pend` and is retried, even if the FIFO already holds data.
- R5: While a request is pending, a claimed read is retried and the pending request is left unchanged in two cases: any of address, command or byte enables differs from the captured values, or `rd_valid` is low in the address phase. This holds whatever the level of `dly_en_n`.
- R6: While a request is pending, a claimed read that matches all three fields with `rd_valid` high in its address phase is served as in R3.
- R7: Once at least one word has moved, a data phase with `rd_valid` low disconnects the transaction: from the next cycle `stop_n` is low and `trdy_n` high.
- R8: The pending request is cleared when a served repeat of it ends after moving at least one word.
- R9: A retry or disconnect drives `stop_n` low with `trdy_n` high and `devsel_n` low. This holds until `frame_n` is sampled high, and all three are released from the cycle after that.
- R10: `rd_ready` is high only when `rd_valid` is high and `irdy_n` is low during a data phase. `trdy_n` and `stop_n` are never low together.
- R11: A word moved in a phase with `frame_n` high ends the transaction with no STOP, and the outputs are idle from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Initiator FRAME, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| addr | input | AW | Address presented in the address phase |
| cmd | input | 4 | Bus command in the address phase |
| be_n | input | 4 | Byte enables in the address phase, active low |
| bar_hit | input | 1 | Address falls in one of the target's windows |
| dly_en_n | input | 1 | Delayed mode enable, active low |
| rd_valid | input | 1 | Read FIFO holds at least one word |
| rd_ready | output | 1 | Pops one FIFO word in the cycle it is high with rd_valid |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| req_pend | output | 1 | A delayed read request is pending |
| req_addr | output | AW | Captured address of the pending request |
| req_cmd | output | 4 | Captured command of the pending request |
| req_be_n | output | 4 | Captured byte enables of the pending request |

## Verification
The FIFO can hand over its final word in the same cycle in which the initiator runs its final data phase. That cycle must end the transaction cleanly and clear the pending request, and it must not signal a disconnect. This is provoked by loading exactly as many words as the burst length, with one run in each mode. It is judged against the other case, a FIFO holding fewer words than the burst. There the target must raise STOP in the cycle after the FIFO empties, and only that run may report a disconnect. Retries of mismatched addresses and byte enables are run while a loaded FIFO waits, to show that stored data is never served to the wrong request.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_RETRY = 2'd2,
    ST_DISC  = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;

  function automatic logic is_read_cmd(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
           (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
  endfunction

endpackage

// File: rtl/dlyrd_phase_det.sv
module dlyrd_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  output logic addr_phase
);
  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  assign addr_phase = !frame_n && frame_q;

  // R2: an address phase never lasts two cycles
  a_r2_single_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);
endmodule

// File: rtl/dlyrd_req_latch.sv
module dlyrd_req_latch #(
  parameter int AW = 32,
  parameter int BW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          clear,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cmd,
  input  logic [BW-1:0] be_n,
  output logic          pend,
  output logic [AW-1:0] q_addr,
  output logic [CW-1:0] q_cmd,
  output logic [BW-1:0] q_be_n,
  output logic          match
);
  localparam int TW = AW + CW + BW;

  logic [TW-1:0] tag_q;
  logic [TW-1:0] tag_in;

  assign tag_in = {addr, cmd, be_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      tag_q <= '0;
    end else if (capture) begin
      pend  <= 1'b1;
      tag_q <= tag_in;
    end else if (clear) begin
      pend  <= 1'b0;
    end
  end

  assign {q_addr, q_cmd, q_be_n} = tag_q;
  assign match = pend && (tag_q == tag_in);

  // R4: a new request is taken only when none is outstanding
  a_r4_capture_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !pend);
  // R5: stored fields do not move while a request is pending
  a_r5_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !capture) |=> $stable(tag_q));
endmodule

// File: rtl/dlyrd_fsm.sv
module dlyrd_fsm
  import dlyrd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_phase,
  input  logic bar_hit,
  input  logic cmd_rd,
  input  logic dly_en_n,
  input  logic pend,
  input  logic match,
  input  logic rd_valid,
  input  logic frame_n,
  input  logic irdy_n,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic rd_ready,
  output logic capture,
  output logic clear
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  tgt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dly_q, dly_d;
  logic             hit, hs, moved;

  assign hit   = addr_phase && bar_hit && cmd_rd;
  assign hs    = (state_q == ST_XFER) && rd_valid && !irdy_n;
  assign moved = (cnt_q != '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    capture = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (hit) begin
          if (pend) begin
            if (match && rd_valid) begin
              state_d = ST_XFER;
              dly_d   = 1'b1;
            end else begin
              state_d = ST_RETRY;
            end
          end else if (!dly_en_n) begin
            capture = 1'b1;
            state_d = ST_RETRY;
          end else begin
            state_d = ST_XFER;
            dly_d   = 1'b0;
          end
        end
      end
      ST_XFER: begin
        if (hs && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (hs && frame_n) begin
          state_d = ST_IDLE;
          clear   = dly_q;
        end else if (!rd_valid && moved) begin
          state_d = ST_DISC;
          clear   = dly_q;
        end else if (frame_n && irdy_n) begin
          state_d = ST_IDLE;
          clear   = dly_q && moved;
        end
      end
      ST_RETRY, ST_DISC: begin
        if (frame_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dly_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dly_q   <= dly_d;
    end
  end

  assign devsel_n = (state_q == ST_IDLE);
  assign stop_n   = !((state_q == ST_RETRY) || (state_q == ST_DISC));
  assign trdy_n   = !((state_q == ST_XFER) && rd_valid);
  assign rd_ready = hs;

  // R2: an address phase that is not a read hit leaves DEVSEL idle
  a_r2_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !(bar_hit && cmd_rd) && state_q == ST_IDLE) |=> devsel_n);
  // R5: a pending request blocks service unless matched with data
  a_r5_retry_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hit && pend && !(match && rd_valid)) |=> (!stop_n && trdy_n && pend));
  // R7: FIFO dry after data moved leads to a disconnect
  a_r7_disc_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && !rd_valid && moved && !(frame_n && irdy_n)) |=> (!stop_n && trdy_n));
  // R9: STOP held while FRAME stays asserted
  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> (!stop_n && !devsel_n));
  // R9: STOP and DEVSEL drop after FRAME is seen high
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && frame_n) |=> (stop_n && devsel_n));
  // R11: final handshake ends without STOP
  a_r11_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && frame_n) |=> (stop_n && devsel_n));
endmodule

// File: rtl/dlyrd_target.sv
module dlyrd_target
  import dlyrd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  input  logic [3:0]    be_n,
  input  logic          bar_hit,
  input  logic          dly_en_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          req_pend,
  output logic [AW-1:0] req_addr,
  output logic [3:0]    req_cmd,
  output logic [3:0]    req_be_n
);
  logic addr_phase, cmd_rd, match, capture, clear;

  assign cmd_rd = is_read_cmd(cmd);

  dlyrd_phase_det u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .addr_phase (addr_phase)
  );

  dlyrd_req_latch #(.AW(AW), .BW(4), .CW(4)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .clear   (clear),
    .addr    (addr),
    .cmd     (cmd),
    .be_n    (be_n),
    .pend    (req_pend),
    .q_addr  (req_addr),
    .q_cmd   (req_cmd),
    .q_be_n  (req_be_n),
    .match   (match)
  );

  dlyrd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .bar_hit    (bar_hit),
    .cmd_rd     (cmd_rd),
    .dly_en_n   (dly_en_n),
    .pend       (req_pend),
    .match      (match),
    .rd_valid   (rd_valid),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .rd_ready   (rd_ready),
    .capture    (capture),
    .clear      (clear)
  );

  // R4: a freshly latched request is always answered with a retry
  a_r4_latch_retries: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pend) |-> (!stop_n && trdy_n));
  // R10: a pop needs data and a ready initiator
  a_r10_pop_rules: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_valid && !irdy_n && !trdy_n));
  // R10: TRDY and STOP never asserted together
  a_r10_trdy_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));
  // R1: no target activity while in reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (devsel_n && stop_n && trdy_n && !rd_ready && !req_pend));
endmodule

// File: tb/dlyrd_target_tb.sv
`timescale 1ns/1ps
module dlyrd_target_tb;
  localparam int AW = 32;
  localparam int NV = 15;

  typedef struct packed {
    logic       dly_n;
    logic       bar;
    logic [3:0] cmd;
    logic [1:0] asel;
    logic [3:0] be_n;
    logic [2:0] load;
    logic [2:0] len;
    logic       claim;
    logic [2:0] words;
    logic       stop;
    logic       pend;
  } vec_t;

  // dly_n bar cmd asel be_n load len | claim words stop pend
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'h6, 2'd0, 4'h0, 3'd4, 3'd4, 1'b1, 3'd4, 1'b0, 1'b0}, // R3 R11 immediate burst
    '{1'b1, 1'b0, 4'h6, 2'd1, 4'h0, 3'd0, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0}, // R2 no window hit
    '{1'b1, 1'b1, 4'h7, 2'd1, 4'h0, 3'd0, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0}, // R2 write not claimed
    '{1'b0, 1'b1, 4'h6, 2'd0, 4'h0, 3'd0, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R4 latch + retry
    '{1'b0, 1'b1, 4'h6, 2'd0, 4'h0, 3'd0, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R5 match, no data
    '{1'b0, 1'b1, 4'h6, 2'd1, 4'h0, 3'd4, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R5 addr mismatch
    '{1'b0, 1'b1, 4'h6, 2'd0, 4'h3, 3'd0, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R5 be mismatch
    '{1'b0, 1'b1, 4'h6, 2'd0, 4'h0, 3'd0, 3'd4, 1'b1, 3'd4, 1'b0, 1'b0}, // R6 R8 R11 served
    '{1'b0, 1'b1, 4'hC, 2'd2, 4'h0, 3'd2, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R4 retry despite data
    '{1'b0, 1'b1, 4'hC, 2'd2, 4'h0, 3'd0, 3'd4, 1'b1, 3'd2, 1'b1, 1'b0}, // R7 R8 short FIFO
    '{1'b0, 1'b1, 4'h2, 2'd3, 4'h0, 3'd0, 3'd2, 1'b1, 3'd0, 1'b1, 1'b1}, // R4 I/O read latched
    '{1'b1, 1'b1, 4'hE, 2'd1, 4'h0, 3'd3, 3'd3, 1'b1, 3'd0, 1'b1, 1'b1}, // R5 pending beats immediate
    '{1'b1, 1'b1, 4'h2, 2'd3, 4'h0, 3'd0, 3'd3, 1'b1, 3'd3, 1'b0, 1'b0}, // R6 R8 served, mode off
    '{1'b1, 1'b1, 4'hE, 2'd1, 4'h0, 3'd1, 3'd3, 1'b1, 3'd1, 1'b1, 1'b0}, // R7 immediate runs dry
    '{1'b0, 1'b1, 4'h6, 2'd0, 4'h0, 3'd0, 3'd4, 1'b1, 3'd0, 1'b1, 1'b1}  // R4 new latch
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_n, irdy_n, bar_hit, dly_en_n;
  logic [AW-1:0] addr;
  logic [3:0]    cmd, be_n;
  logic          rd_valid, rd_ready;
  logic          devsel_n, trdy_n, stop_n, req_pend;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_cmd, req_be_n;

  int fifo_cnt;
  int fifo_add;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign rd_valid = (fifo_cnt > 0);

  always @(posedge clk) begin
    if (!rst_n) fifo_cnt <= 0;
    else        fifo_cnt <= fifo_cnt + fifo_add - (rd_ready ? 1 : 0);
  end

  dlyrd_target #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr(addr), .cmd(cmd), .be_n(be_n), .bar_hit(bar_hit),
    .dly_en_n(dly_en_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .req_pend(req_pend), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_be_n(req_be_n)
  );

  function automatic logic [AW-1:0] addr_of(input logic [1:0] s);
    return 32'h1000_0040 + {22'd0, s, 8'd0};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "devsel_n idle", devsel_n, 1);
    chk(req, "trdy_n idle",   trdy_n,   1);
    chk(req, "stop_n idle",   stop_n,   1);
    chk(req, "rd_ready idle", rd_ready, 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int  words;
    bit  claimed, saw_stop, saw_both, done;
    // load FIFO one cycle ahead of the address phase
    @(negedge clk);
    fifo_add = int'(v.load);
    dly_en_n = v.dly_n;
    @(posedge clk); #1;
    fifo_add = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; bar_hit = v.bar;
    cmd = v.cmd; be_n = v.be_n; addr = addr_of(v.asel);
    @(posedge clk); #1;
    bar_hit = 1'b0; cmd = 4'h0; be_n = 4'hF; addr = '0;
    irdy_n  = 1'b0; frame_n = (v.len == 3'd1);
    words = 0; claimed = 0; saw_stop = 0; saw_both = 0; done = 0;
    for (int c = 0; c < 16 && !done; c++) begin
      bit hs, nf, ni;
      @(negedge clk);
      if (!devsel_n) claimed = 1;
      if (!stop_n) saw_stop = 1;
      if (!stop_n && !trdy_n) saw_both = 1;
      hs = !trdy_n && !irdy_n;
      if (hs) words++;
      if (hs) chk("R10", $sformatf("v%0d pop with handshake", idx), rd_ready, 1);
      nf = frame_n; ni = irdy_n;
      if (!stop_n || (hs && frame_n) || (!claimed && c >= 4)) begin
        nf = 1'b1; ni = 1'b1; done = 1;
      end else if (hs && words == int'(v.len) - 1) begin
        nf = 1'b1;
      end
      @(posedge clk); #1;
      frame_n = nf; irdy_n = ni;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2",  $sformatf("v%0d claimed", idx), claimed, v.claim);
    chk("R3",  $sformatf("v%0d words", idx), words, v.words);
    chk("R9",  $sformatf("v%0d stop seen", idx), saw_stop, v.stop);
    chk("R8",  $sformatf("v%0d pending after", idx), req_pend, v.pend);
    chk("R10", $sformatf("v%0d trdy+stop", idx), saw_both, 0);
    check_idle("R9");
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; bar_hit = 1'b0;
    dly_en_n = 1'b1; addr = '0; cmd = 4'h0; be_n = 4'hF; fifo_add = 0;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check_idle("R1");
    chk("R1", "req_pend in reset", req_pend, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R4: captured fields of the last latched request
    chk("R4", "req_addr", req_addr, addr_of(2'd0));
    chk("R4", "req_cmd", req_cmd, 4'h6);
    chk("R4", "req_be_n", req_be_n, 4'h0);

    // R1: reset drops a pending request
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "req_pend cleared by reset", req_pend, 0);
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: after reset a new delayed read latches fresh fields
    run_vec('{1'b0, 1'b1, 4'hE, 2'd3, 4'hA, 3'd0, 3'd2, 1'b1, 3'd0, 1'b1, 1'b1}, 99);
    chk("R4", "req_addr fresh", req_addr, addr_of(2'd3));
    chk("R4", "req_cmd fresh", req_cmd, 4'hE);
    chk("R4", "req_be_n fresh", req_be_n, 4'hA);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule